// File: doc/BRIEF.md
# Forwarded-Clock Framed Word Receiver

This block takes a serial line that carries 32-bit words one bit at a time, together with the bit clock that the sender forwards alongside the data. The line rests high between frames. A low bit marks the start of a frame. The receiver then shifts in the payload, a parity bit and two stop bits, and checks the parity and the framing. Each accepted word is handed across to the system clock domain through a small dual-clock FIFO.

On the system side, words come out on a valid/ready stream, and every word carries its own parity-error flag. The producer is the serial line, and it cannot be stalled. Back-pressure from `rx_ready` therefore only fills the FIFO. If a word completes while the FIFO is full, that word is dropped and an overflow pulse is raised. A frame with a bad stop bit never enters the FIFO. It only raises a framing-error pulse. Both of these error pulses belong to the line clock domain.

Top module: `fsr_rx`

## Requirements
- R1: A frame is one start bit (0), then 32 data bits, then a parity bit, then two stop bits (1), for 36 line clock periods in all. The line is sampled on the rising edge of `line_clk`.
- R2: Data bits arrive most significant bit first. An accepted word appears unchanged on `rx_data` with `rx_valid` high.
- R3: Parity is odd over the 32 data bits: the data ones plus the parity bit must total an odd number. A word with correct parity is delivered with `rx_perr` = 0.
- R4: A word whose parity does not match is still delivered, with `rx_perr` = 1.
- R5: If either stop bit is 0, `frm_err` pulses high for one `line_clk` cycle and the word is discarded, so nothing reaches `rx_valid`.
- R6: A line held at 1 produces no word and no error.
- R7: A new start bit may follow the second stop bit directly. Back-to-back frames are all received.
- R8: A word that completes while the FIFO (depth `FIFO_DEPTH`, at least 4) is full is dropped. `ovf` pulses for one `line_clk` cycle, and the stored words are unaffected.
- R9: Words leave in arrival order. A word is consumed on a `sys_clk` edge where `rx_valid` and `rx_ready` are both high.
- R10: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_perr` hold their values.
- R11: After reset, `rx_valid`, `frm_err` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Bit clock forwarded by the sender |
| line_rst_n | input | 1 | Active-low reset, line domain |
| line_din | input | 1 | Serial data, idles high |
| frm_err | output | 1 | One-cycle pulse: a stop bit was 0, word dropped |
| ovf | output | 1 | One-cycle pulse: FIFO full, word dropped |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| rx_valid | output | 1 | A received word is available |
| rx_ready | input | 1 | Consumer accepts the word |
| rx_data | output | 32 | Received word |
| rx_perr | output | 1 | Parity error flag of this word |

## Verification
The hardest state to reach is a full FIFO together with a word arriving that must be dropped. The serial line needs 36 line clocks per word, and the consumer normally drains faster than that. The bench reaches this state by holding `rx_ready` low while it sends `FIFO_DEPTH` frames and then one more. It then confirms a single overflow pulse and drains the FIFO, which must return exactly the first words in order and nothing after them. Stop-bit faults are injected in each stop position separately, so that both framing checks are exercised.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_st_e;

  function automatic logic [7:0] gray2bin(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fsr_framer.sv
module fsr_framer
  import fsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic         word_vld,
  output logic [W-1:0] word,
  output logic         perr,
  output logic         frm_err
);
  localparam int CW = $clog2(W);

  rx_st_e       st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic          par_q;
  logic          s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      par_q    <= 1'b0;
      s1_q     <= 1'b0;
      word_vld <= 1'b0;
      word     <= '0;
      perr     <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      frm_err  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!din) begin
            st  <= ST_DATA;
            cnt <= '0;
          end
        end
        ST_DATA: begin
          sh <= {sh[W-2:0], din};
          if (cnt == CW'(W - 1)) st <= ST_PAR;
          else                   cnt <= cnt + 1'b1;
        end
        ST_PAR: begin
          par_q <= din;
          st    <= ST_STOP1;
        end
        ST_STOP1: begin
          s1_q <= din;
          st   <= ST_STOP2;
        end
        ST_STOP2: begin
          st <= ST_IDLE;
          if (s1_q && din) begin
            word_vld <= 1'b1;
            word     <= sh;
            perr     <= ~(^sh ^ par_q);
          end else begin
            frm_err <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && frm_err)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && din) |=> (st == ST_IDLE && !word_vld && !frm_err)); // R6
  AST_PAR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAR) |-> ($past(st) == ST_DATA)); // R1
endmodule

// File: rtl/fsr_cdc_fifo.sv
module fsr_cdc_fifo
  import fsr_pkg::*;
#(
  parameter int DW    = 33,
  parameter int DEPTH = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic          ovf,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic          full, empty, push, pop;
  logic [PW-1:0] wbin_n, rbin_n;

  fsr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  fsr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  // write side
  assign full   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign push   = wr_req && !full;
  assign wbin_n = wbin + 1'b1;

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wr_req && full;
      if (push) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  // read side
  assign empty    = (rgray == wgray_r);
  assign rd_valid = !empty;
  assign rd_data  = mem[rbin[AW-1:0]];
  assign pop      = rd_valid && rd_ready;
  assign rbin_n   = rbin + 1'b1;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  logic [7:0] wbin_r8;
  assign wbin_r8 = gray2bin(8'(wgray_r));

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && full) |=> $stable(wbin)); // R8
  AST_OCC_BOUND: assert property (@(posedge rclk) disable iff (!rrst_n)
    (PW'(wbin_r8) - rbin) <= PW'(DEPTH)); // R9
  AST_HOLD_UNDER_STALL: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

// File: rtl/fsr_rx.sv
module fsr_rx #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              line_clk,
  input  logic              line_rst_n,
  input  logic              line_din,
  output logic              frm_err,
  output logic              ovf,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_perr
);
  localparam int DW = WORD_W + 1;

  logic              w_vld;
  logic [WORD_W-1:0] w_word;
  logic              w_perr;
  logic [DW-1:0]     rd_bus;

  fsr_framer #(.W(WORD_W)) u_framer (
    .clk(line_clk), .rst_n(line_rst_n), .din(line_din),
    .word_vld(w_vld), .word(w_word), .perr(w_perr), .frm_err(frm_err)
  );

  fsr_cdc_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk(line_clk), .wrst_n(line_rst_n), .wr_req(w_vld),
    .wdata({w_perr, w_word}), .ovf(ovf),
    .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_valid(rx_valid),
    .rd_ready(rx_ready), .rd_data(rd_bus)
  );

  assign rx_perr = rd_bus[DW-1];
  assign rx_data = rd_bus[WORD_W-1:0];

  AST_RESET_QUIET: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(sys_rst_n) |-> !rx_valid); // R11
endmodule

// File: tb/fsr_rx_bench.sv
module fsr_rx_bench;
  localparam time LINE_PERIOD = 25ns;
  localparam time SYS_PERIOD  = 10ns;
  localparam int  DEPTH       = 4;

  logic        line_clk = 0, sys_clk = 0;
  logic        line_rst_n = 0, sys_rst_n = 0;
  logic        line_din = 1'b1;
  logic        rx_ready = 1'b0;
  logic        frm_err, ovf, rx_valid, rx_perr;
  logic [31:0] rx_data;

  int n_chk = 0, n_bad = 0, frm_cnt = 0, ovf_cnt = 0;
  bit done = 0;

  always #(LINE_PERIOD/2) line_clk = ~line_clk;
  always #(SYS_PERIOD/2)  sys_clk  = ~sys_clk;

  fsr_rx #(.WORD_W(32), .FIFO_DEPTH(DEPTH)) u_fsr_rx (
    .line_clk(line_clk), .line_rst_n(line_rst_n), .line_din(line_din),
    .frm_err(frm_err), .ovf(ovf),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr)
  );

  always @(negedge line_clk) begin
    if (frm_err) frm_cnt++;
    if (ovf)     ovf_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flip_par inverts the odd parity bit; s1/s2 are the stop bit values
  task automatic send_frame(input logic [31:0] d, input bit flip_par, input bit s1, input bit s2);
    @(negedge line_clk) line_din = 1'b0;
    for (int i = 31; i >= 0; i--) @(negedge line_clk) line_din = d[i];
    @(negedge line_clk) line_din = ~(^d) ^ flip_par;
    @(negedge line_clk) line_din = s1;
    @(negedge line_clk) line_din = s2;
  endtask

  task automatic idle_line(input int n);
    @(negedge line_clk) line_din = 1'b1;
    repeat (n) @(negedge line_clk);
  endtask

  task automatic pop_word(input logic [31:0] exp_d, input bit exp_p, input string tag);
    int t = 0;
    @(negedge sys_clk);
    while (!rx_valid && t < 400) begin @(negedge sys_clk); t++; end
    chk(rx_valid, {tag, " valid"}, 64'(rx_valid), 64'd1);
    chk(rx_data == exp_d, {tag, " data"}, 64'(rx_data), 64'(exp_d));
    chk(rx_perr == exp_p, {tag, " perr"}, 64'(rx_perr), 64'(exp_p));
    rx_ready = 1'b1;
    @(negedge sys_clk) rx_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    repeat (20) @(negedge sys_clk);
    chk(!rx_valid, tag, 64'(rx_valid), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge sys_clk);
    chk(!rx_valid, "R11 rx_valid", 64'(rx_valid), 0);
    chk(!frm_err && !ovf, "R11 flags", 64'({frm_err, ovf}), 0);
  endtask

  task automatic t_good;
    send_frame(32'hA5C3_0F81, 0, 1, 1); idle_line(4);
    pop_word(32'hA5C3_0F81, 0, "R1 R2 R3 good word");
    send_frame(32'h0000_0000, 0, 1, 1); idle_line(4);
    pop_word(32'h0000_0000, 0, "R3 zero word");
  endtask

  task automatic t_parity;
    send_frame(32'h1234_5678, 1, 1, 1); idle_line(4);
    pop_word(32'h1234_5678, 1, "R4 bad parity delivered");
  endtask

  task automatic t_framing;
    int f0 = frm_cnt;
    send_frame(32'hDEAD_BEEF, 0, 0, 1); idle_line(4);
    chk(frm_cnt == f0 + 1, "R5 stop1 frm_err", 64'(frm_cnt - f0), 1);
    expect_empty("R5 stop1 discarded");
    send_frame(32'hCAFE_0001, 0, 1, 0); idle_line(4);
    chk(frm_cnt == f0 + 2, "R5 stop2 frm_err", 64'(frm_cnt - f0), 2);
    expect_empty("R5 stop2 discarded");
  endtask

  task automatic t_idle;
    int f0 = frm_cnt;
    idle_line(100);
    chk(frm_cnt == f0 && !rx_valid, "R6 idle quiet", 64'(frm_cnt - f0), 0);
  endtask

  task automatic t_b2b;
    send_frame(32'h8000_0001, 0, 1, 1);
    send_frame(32'h7FFF_FFFE, 1, 1, 1);
    send_frame(32'h0F0F_F0F0, 0, 1, 1);
    idle_line(4);
    pop_word(32'h8000_0001, 0, "R7 b2b first");
    pop_word(32'h7FFF_FFFE, 1, "R7 b2b second");
    pop_word(32'h0F0F_F0F0, 0, "R7 b2b third");
  endtask

  task automatic t_overflow;
    int o0 = ovf_cnt;
    logic [31:0] first;
    for (int k = 0; k < DEPTH + 1; k++) send_frame(32'h1000_0000 + 32'(k), 0, 1, 1);
    idle_line(8);
    chk(ovf_cnt == o0 + 1, "R8 ovf pulse", 64'(ovf_cnt - o0), 1);
    @(negedge sys_clk) first = rx_data;
    repeat (10) @(negedge sys_clk);
    chk(rx_valid && rx_data == first && first == 32'h1000_0000, "R10 held under stall",
        64'(rx_data), 64'h1000_0000);
    for (int k = 0; k < DEPTH; k++) pop_word(32'h1000_0000 + 32'(k), 0, "R9 order after stall");
    expect_empty("R8 extra word dropped");
  endtask

  initial begin
    #(LINE_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge line_clk);
    t_reset();
    line_rst_n = 1; sys_rst_n = 1;
    idle_line(5);
    t_good();
    t_parity();
    t_framing();
    t_idle();
    t_b2b();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule